// File: doc/BRIEF.md
# Timer Slave-Mode and Quadrature Controller

This block sits beside a timer's time base and decides, every clock, whether the counter advances, in which direction, whether it must be reinitialized with a register update, and whether counter enable must be set. The decision comes from a 4-bit mode field. The mode picks either a pair of quadrature inputs (A and B) or one trigger source. A select field picks that trigger from the internal timer triggers, a both-edge detector on input A, input A, input B, or an external trigger line.

Every external input passes through a two-stage synchronizer. A third register holds the previous synchronized value for edge detection. The four command outputs are registered. A change on any input therefore reaches the outputs after the third rising clock edge. The run input reflects the time base's counter-enable bit. Every counting action is gated by it. A start request is the block's way of asking for that bit to be set.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: While rst_ni is low, cnt_step_o, cnt_reinit_o and cnt_start_o are 0 and cnt_up_o is 1.
- R2: An input change that is present at rising edge m shows on the outputs after rising edge m+2, with the default of two synchronizer stages. Mode and select act on the output register directly.
- R3: Mode 0 and the reserved modes 9 to 15 give no slave control: cnt_step_o follows cnt_run_i with one cycle of delay. cnt_up_o is 1. No reinit and no start are issued.
- R4: Mode 1 issues one step per edge of B. The step is up when B equals A after the edge and down otherwise. cnt_up_o is 0 only in a cycle that strobes a down step.
- R5: Mode 2 issues one step per edge of A. The step is up when A differs from B after the edge.
- R6: Mode 3 steps on edges of either input, with the direction rule of R4 for B and of R5 for A. When A and B change in the same cycle, no step is issued.
- R7: Mode 4 issues cnt_reinit_o for one cycle on each rising trigger edge. Steps follow cnt_run_i. A falling edge has no effect.
- R8: Mode 5 issues a step in every cycle in which the trigger level is high and cnt_run_i is 1. No step is issued while the trigger is low.
- R9: Mode 6 issues cnt_start_o for one cycle on each rising trigger edge, whatever the value of cnt_run_i. It never issues cnt_reinit_o.
- R10: Mode 7 issues one step per rising trigger edge, and only while cnt_run_i is 1.
- R11: Mode 8 issues cnt_reinit_o and cnt_start_o together, for one cycle, on each rising trigger edge.
- R12: The trigger select codes are as follows. Codes 0 to 3 pick internal trigger 0 to 3. Code 4 picks a one-cycle pulse on every edge of A, which serves as both level and rising edge. Code 5 picks A, code 6 picks B and code 7 picks the external trigger.
- R13: A trigger held high produces exactly one edge-driven strobe, however long it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Slave mode code |
| trig_sel_i | input | SEL_W (3) | Trigger source select |
| cnt_run_i | input | 1 | Counter enable state of the time base |
| itrig_i | input | NUM_ITR (4) | Internal timer triggers |
| enc_a_i | input | 1 | Timer input A (quadrature phase A) |
| enc_b_i | input | 1 | Timer input B (quadrature phase B) |
| ext_trig_i | input | 1 | External trigger |
| cnt_step_o | output | 1 | Count-enable strobe for the counter |
| cnt_up_o | output | 1 | Count direction, 1 = up |
| cnt_reinit_o | output | 1 | Reinitialize the counter and update its registers |
| cnt_start_o | output | 1 | Request to set counter enable |

## Verification
The bench builds the block with its defaults: four internal triggers and two synchronizer stages. With these values the select field is three bits and every one of its eight codes maps to a real source. The bench therefore pulses each source under each select code and sees that only the chosen one counts. The two-stage default fixes the three-edge input latency that the bench's history model reproduces. It also lets that latency be checked against an exact edge.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;

  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    SM_OFF       = 4'd0,
    SM_ENC_B     = 4'd1,
    SM_ENC_A     = 4'd2,
    SM_ENC_AB    = 4'd3,
    SM_RESET     = 4'd4,
    SM_GATED     = 4'd5,
    SM_TRIG      = 4'd6,
    SM_EXTCLK    = 4'd7,
    SM_RST_START = 4'd8
  } slave_mode_e;

  typedef struct packed {
    logic step;
    logic up;
    logic reinit;
    logic start;
  } tb_cmd_t;

  localparam tb_cmd_t CMD_IDLE = '{step: 1'b0, up: 1'b1, reinit: 1'b0, start: 1'b0};

endpackage

// File: rtl/tmr_slave_sync.sv
module tmr_slave_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);
  // stages 0..STAGES-1 synchronize, last stage holds previous level
  localparam int unsigned DEPTH = STAGES + 1;

  logic [WIDTH-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign prev_o = stg_q[STAGES];

endmodule

// File: rtl/tmr_slave_trig.sv
module tmr_slave_trig #(
  parameter int unsigned NUM_ITR = 4,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [NUM_ITR+2:0] lvl_i,
  input  logic [NUM_ITR+2:0] prev_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               trig_lvl_o,
  output logic               trig_rise_o
);
  localparam int unsigned NUM_SRC = NUM_ITR + 4;
  localparam int unsigned PAD_W   = 2 ** SEL_W;
  localparam int unsigned IDX_A   = NUM_ITR;
  localparam int unsigned IDX_B   = NUM_ITR + 1;
  localparam int unsigned IDX_E   = NUM_ITR + 2;

  logic [NUM_SRC-1:0] src_lvl, src_rise;
  logic [PAD_W-1:0]   lvl_pad, rise_pad;
  logic               a_tog;

  for (genvar g = 0; g < NUM_ITR; g++) begin : g_itr
    assign src_lvl[g]  = lvl_i[g];
    assign src_rise[g] = lvl_i[g] & ~prev_i[g];
  end

  assign a_tog = lvl_i[IDX_A] ^ prev_i[IDX_A];

  // both-edge detector on A acts as level and edge alike
  assign src_lvl[NUM_ITR]    = a_tog;
  assign src_rise[NUM_ITR]   = a_tog;
  assign src_lvl[NUM_ITR+1]  = lvl_i[IDX_A];
  assign src_rise[NUM_ITR+1] = lvl_i[IDX_A] & ~prev_i[IDX_A];
  assign src_lvl[NUM_ITR+2]  = lvl_i[IDX_B];
  assign src_rise[NUM_ITR+2] = lvl_i[IDX_B] & ~prev_i[IDX_B];
  assign src_lvl[NUM_ITR+3]  = lvl_i[IDX_E];
  assign src_rise[NUM_ITR+3] = lvl_i[IDX_E] & ~prev_i[IDX_E];

  always_comb begin
    lvl_pad  = '0;
    rise_pad = '0;
    lvl_pad[NUM_SRC-1:0]  = src_lvl;
    rise_pad[NUM_SRC-1:0] = src_rise;
  end

  assign trig_lvl_o  = lvl_pad[sel_i];
  assign trig_rise_o = rise_pad[sel_i];

endmodule

// File: rtl/tmr_slave_quad.sv
module tmr_slave_quad (
  input  logic a_i,
  input  logic a_prev_i,
  input  logic b_i,
  input  logic b_prev_i,
  input  logic use_a_i,
  input  logic use_b_i,
  output logic step_o,
  output logic up_o
);
  logic cnt_a, cnt_b;

  assign cnt_a = use_a_i & (a_i ^ a_prev_i);
  assign cnt_b = use_b_i & (b_i ^ b_prev_i);

  always_comb begin
    step_o = cnt_a ^ cnt_b;  // simultaneous edges are discarded
    up_o   = 1'b1;
    if (cnt_a && !cnt_b)      up_o = (a_i != b_i);
    else if (cnt_b && !cnt_a) up_o = (a_i == b_i);
  end

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tmr_slave_pkg::*;
#(
  parameter int unsigned NUM_ITR     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = $clog2(NUM_ITR + 4)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [SEL_W-1:0]   trig_sel_i,
  input  logic               cnt_run_i,
  input  logic [NUM_ITR-1:0] itrig_i,
  input  logic               enc_a_i,
  input  logic               enc_b_i,
  input  logic               ext_trig_i,
  output logic               cnt_step_o,
  output logic               cnt_up_o,
  output logic               cnt_reinit_o,
  output logic               cnt_start_o
);
  localparam int unsigned IN_W  = NUM_ITR + 3;
  localparam int unsigned IDX_A = NUM_ITR;
  localparam int unsigned IDX_B = NUM_ITR + 1;

  logic [IN_W-1:0] raw, lvl, prev;
  logic            trig_lvl, trig_rise;
  logic            use_a, use_b, q_step, q_up;
  slave_mode_e     mode;
  tb_cmd_t         nxt, cmd_q;

  assign raw  = {ext_trig_i, enc_b_i, enc_a_i, itrig_i};
  assign mode = slave_mode_e'(mode_i);

  tmr_slave_sync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  tmr_slave_trig #(
    .NUM_ITR (NUM_ITR),
    .SEL_W   (SEL_W)
  ) i_trig (
    .lvl_i       (lvl),
    .prev_i      (prev),
    .sel_i       (trig_sel_i),
    .trig_lvl_o  (trig_lvl),
    .trig_rise_o (trig_rise)
  );

  assign use_a = (mode == SM_ENC_A) || (mode == SM_ENC_AB);
  assign use_b = (mode == SM_ENC_B) || (mode == SM_ENC_AB);

  tmr_slave_quad i_quad (
    .a_i      (lvl[IDX_A]),
    .a_prev_i (prev[IDX_A]),
    .b_i      (lvl[IDX_B]),
    .b_prev_i (prev[IDX_B]),
    .use_a_i  (use_a),
    .use_b_i  (use_b),
    .step_o   (q_step),
    .up_o     (q_up)
  );

  always_comb begin
    nxt = CMD_IDLE;
    unique case (mode)
      SM_ENC_B, SM_ENC_A, SM_ENC_AB: begin
        nxt.step = cnt_run_i & q_step;
        nxt.up   = ~(cnt_run_i & q_step & ~q_up);
      end
      SM_RESET: begin
        nxt.step   = cnt_run_i;
        nxt.reinit = trig_rise;
      end
      SM_GATED:  nxt.step = cnt_run_i & trig_lvl;
      SM_TRIG: begin
        nxt.step  = cnt_run_i;
        nxt.start = trig_rise;
      end
      SM_EXTCLK: nxt.step = cnt_run_i & trig_rise;
      SM_RST_START: begin
        nxt.step   = cnt_run_i;
        nxt.reinit = trig_rise;
        nxt.start  = trig_rise;
      end
      default:   nxt.step = cnt_run_i;  // off and reserved codes
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= CMD_IDLE;
    else         cmd_q <= nxt;
  end

  assign cnt_step_o   = cmd_q.step;
  assign cnt_up_o     = cmd_q.up;
  assign cnt_reinit_o = cmd_q.reinit;
  assign cnt_start_o  = cmd_q.start;

endmodule

// File: rtl/tmr_slave_chk.sv
module tmr_slave_chk
  import tmr_slave_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_i,
  input logic              cnt_run_i,
  input logic              cnt_step_o,
  input logic              cnt_up_o,
  input logic              cnt_reinit_o,
  input logic              cnt_start_o
);
  logic live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_free_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(cnt_run_i) && ($past(mode_i) == SM_OFF || $past(mode_i) > SM_RST_START))
      |-> (cnt_step_o && cnt_up_o && !cnt_reinit_o && !cnt_start_o));

  // also covers R5 and R6
  assert_down_enc_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !cnt_up_o)
      |-> (cnt_step_o && ($past(mode_i) == SM_ENC_B || $past(mode_i) == SM_ENC_A ||
                          $past(mode_i) == SM_ENC_AB)));

  assert_reinit_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && cnt_reinit_o)
      |-> ($past(mode_i) == SM_RESET || $past(mode_i) == SM_RST_START));

  assert_start_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && cnt_start_o)
      |-> ($past(mode_i) == SM_TRIG || $past(mode_i) == SM_RST_START));

  assert_step_needs_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && cnt_step_o) |-> $past(cnt_run_i));

  assert_pair_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(mode_i) == SM_RST_START) |-> (cnt_reinit_o == cnt_start_o));

endmodule

bind tmr_slave_ctrl tmr_slave_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .cnt_run_i    (cnt_run_i),
  .cnt_step_o   (cnt_step_o),
  .cnt_up_o     (cnt_up_o),
  .cnt_reinit_o (cnt_reinit_o),
  .cnt_start_o  (cnt_start_o)
);

// File: tb/test_tmr_slave_ctrl.sv
module test_tmr_slave_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_ITR    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode = 4'd0;
  logic [2:0] sel = 3'd7;
  logic       run = 1'b0;
  logic [3:0] itr = 4'd0;
  logic       a = 1'b0, b = 1'b0, etr = 1'b0;
  logic       step, up, reinit, start;

  int    total = 0, bad = 0;
  string cur_req = "R1";
  bit    chk_on = 1'b0, done = 1'b0;
  int    step_cnt = 0, down_cnt = 0, reinit_cnt = 0, start_cnt = 0;
  int    qph = 0;
  logic [3:0] exp_cmd = 4'b0100;
  logic [6:0] hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_slave_ctrl #(.NUM_ITR(NUM_ITR)) i_tmr_slave_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .trig_sel_i(sel), .cnt_run_i(run),
    .itrig_i(itr), .enc_a_i(a), .enc_b_i(b), .ext_trig_i(etr),
    .cnt_step_o(step), .cnt_up_o(up), .cnt_reinit_o(reinit), .cnt_start_o(start)
  );

  // returns {step, up, reinit, start}; cur/prv bits: 3:0 itr, 4 A, 5 B, 6 ext
  function automatic logic [3:0] ref_cmd(logic [6:0] cur, logic [6:0] prv,
                                         logic [3:0] md, logic [2:0] sl, logic rn);
    bit ca = cur[4], cb = cur[5];
    bit ea = cur[4] ^ prv[4], eb = cur[5] ^ prv[5];
    bit tl, tr, stp = 0, u = 1, ri = 0, st = 0;
    if (sl < 3'd4)       begin tl = cur[sl]; tr = cur[sl] && !prv[sl]; end
    else if (sl == 3'd4) begin tl = ea;      tr = ea; end
    else if (sl == 3'd5) begin tl = cur[4];  tr = cur[4] && !prv[4]; end
    else if (sl == 3'd6) begin tl = cur[5];  tr = cur[5] && !prv[5]; end
    else                 begin tl = cur[6];  tr = cur[6] && !prv[6]; end
    case (md)
      4'd1: if (rn && eb) begin stp = 1; u = (ca == cb); end
      4'd2: if (rn && ea) begin stp = 1; u = (ca != cb); end
      4'd3: if (rn && (ea != eb)) begin stp = 1; u = ea ? (ca != cb) : (ca == cb); end
      4'd4: begin stp = rn; ri = tr; end
      4'd5: stp = rn && tl;
      4'd6: begin stp = rn; st = tr; end
      4'd7: stp = rn && tr;
      4'd8: begin stp = rn; ri = tr; st = tr; end
      default: stp = rn;
    endcase
    return {stp, u, ri, st};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{7'd0, 7'd0, 7'd0};
      exp_cmd = 4'b0100;
    end else begin
      exp_cmd = ref_cmd(hist[1], hist[2], mode, sel, run);
      hist.push_front({etr, b, a, itr});
      void'(hist.pop_back());
    end
  end

  // per-clock comparison, sampled a quarter period after the edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && chk_on) begin
      total++;
      if ({step, up, reinit, start} !== exp_cmd) begin
        bad++;
        $display("FAIL %s cycle model: actual=%b expected=%b", cur_req,
                 {step, up, reinit, start}, exp_cmd);
      end
      if (step) step_cnt++;
      if (step && !up) down_cnt++;
      if (reinit) reinit_cnt++;
      if (start) start_cnt++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    step_cnt = 0; down_cnt = 0; reinit_cnt = 0; start_cnt = 0;
  endtask

  task automatic set_src(input int k, input logic v);
    case (k)
      0, 1, 2, 3: itr[k] = v;
      4: a = v;
      5: b = v;
      default: etr = v;
    endcase
  endtask

  task automatic pulse(input int k, input int hi, input int lo);
    @(negedge clk); set_src(k, 1'b1);
    idle(hi);       set_src(k, 1'b0);
    idle(lo);
  endtask

  task automatic quad(input bit fwd, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      qph = fwd ? (qph + 1) % 4 : (qph + 3) % 4;
      a = (qph == 1 || qph == 2);
      b = (qph == 2 || qph == 3);
      idle(3);
    end
    idle(4);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R1 reset values
    idle(3);
    #(CLK_PERIOD/4);
    chk("R1", "reset outputs", int'({step, up, reinit, start}), 4);
    @(negedge clk); rst_n = 1'b1; chk_on = 1'b1;
    idle(4);

    // R3 free-running and reserved codes
    cur_req = "R3"; mode = 4'd0; clr();
    run = 1'b1; idle(20); run = 1'b0; idle(4);
    chk("R3", "mode 0 steps", step_cnt, 20);
    chk("R3", "mode 0 reinit+start", reinit_cnt + start_cnt, 0);
    mode = 4'd12; clr(); run = 1'b1; idle(7); run = 1'b0; idle(4);
    chk("R3", "reserved mode steps", step_cnt, 7);

    // R4 edges of B
    run = 1'b1; cur_req = "R4"; mode = 4'd1; idle(4);
    clr(); quad(1'b1, 8);
    chk("R4", "forward steps", step_cnt, 4);
    chk("R4", "forward downs", down_cnt, 0);
    clr(); quad(1'b0, 8);
    chk("R4", "reverse downs", down_cnt, 4);

    // R5 edges of A
    cur_req = "R5"; mode = 4'd2; idle(4);
    clr(); quad(1'b1, 8);
    chk("R5", "forward steps", step_cnt, 4);
    chk("R5", "forward downs", down_cnt, 0);
    clr(); quad(1'b0, 8);
    chk("R5", "reverse downs", down_cnt, 4);

    // R6 both edges
    cur_req = "R6"; mode = 4'd3; idle(4);
    clr(); quad(1'b1, 8);
    chk("R6", "forward steps", step_cnt, 8);
    chk("R6", "forward downs", down_cnt, 0);
    clr(); quad(1'b0, 8);
    chk("R6", "reverse downs", down_cnt, 8);
    clr();
    @(negedge clk); a = 1'b1; b = 1'b1; idle(4);
    a = 1'b0; b = 1'b0; idle(6);
    chk("R6", "simultaneous edges", step_cnt, 0);

    // R7 reset mode on external trigger
    cur_req = "R7"; mode = 4'd4; sel = 3'd7; idle(4); clr();
    for (int i = 0; i < 3; i++) pulse(6, 2, 4);
    idle(4);
    chk("R7", "reinit count", reinit_cnt, 3);
    chk("R7", "start count", start_cnt, 0);

    // R8 gated
    cur_req = "R8"; mode = 4'd5; idle(4); clr();
    pulse(6, 6, 8);
    chk("R8", "gated steps", step_cnt, 6);
    clr(); idle(8);
    chk("R8", "low gate steps", step_cnt, 0);

    // R9 trigger start with run low
    cur_req = "R9"; mode = 4'd6; run = 1'b0; idle(4); clr();
    pulse(6, 3, 5);
    chk("R9", "start count", start_cnt, 1);
    chk("R9", "reinit count", reinit_cnt, 0);

    // R10 external clock
    cur_req = "R10"; mode = 4'd7; run = 1'b1; idle(4); clr();
    for (int i = 0; i < 4; i++) pulse(6, 1, 3);
    idle(4);
    chk("R10", "clocked steps", step_cnt, 4);
    run = 1'b0; clr();
    for (int i = 0; i < 2; i++) pulse(6, 1, 3);
    idle(4);
    chk("R10", "steps with run low", step_cnt, 0);

    // R11 reset plus start
    cur_req = "R11"; mode = 4'd8; run = 1'b1; idle(4); clr();
    for (int i = 0; i < 2; i++) pulse(6, 2, 4);
    idle(4);
    chk("R11", "reinit count", reinit_cnt, 2);
    chk("R11", "start count", start_cnt, 2);

    // R12 trigger select
    cur_req = "R12"; mode = 4'd7;
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s); idle(4); clr();
      for (int k = 0; k < 7; k++) pulse(k, 2, 4);
      idle(4);
      chk("R12", $sformatf("steps for select %0d", s), step_cnt, (s == 4) ? 2 : 1);
    end

    // R13 held trigger gives a single strobe
    cur_req = "R13"; sel = 3'd7; idle(4); clr();
    pulse(6, 12, 6);
    chk("R13", "held trigger steps", step_cnt, 1);

    // R2 latency of three edges
    cur_req = "R2"; idle(4);
    @(negedge clk); etr = 1'b1;
    @(posedge clk); @(posedge clk); #(CLK_PERIOD/4);
    chk("R2", "step after two edges", int'(step), 0);
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R2", "step after three edges", int'(step), 1);
    @(negedge clk); etr = 1'b0; idle(6);

    done = 1'b1;
    finish_run();
  end

endmodule